// File: doc/BRIEF.md
# PHY Register Access Bus Controller

This block sits between a simple host register port and an 8-bit microprocessor-style bus that reaches one or two external PHY devices. It holds a control register and a sticky status register. Host accesses to a 4 KiB data window become chip-select, read and write strobe cycles on the PHY bus. When the framer-select control bit is set, the same window is instead routed to an internal framer register port. A front-end enable bit gates every data transfer. A hardware-error link bit lets an external master-enable signal clear that enable.

The PHY bus runs in one of two modes, chosen at run time. In the fixed-timing mode, every transfer holds its strobes for a window of 200 ns. That window is turned into a cycle count from the clock period parameter. In the handshake mode, the strobes are held until the PHY raises an acknowledge. If no acknowledge arrives within a timeout, the access ends and an error is recorded. Reads are checked for odd parity when parity checking is enabled. One control bit inverts both the polarity of the two PHY interrupt inputs and the polarity of the PHY reset output.

Top module: `phy_bus_ctrl`

## Requirements
- R1: After reset, the control register (host offset 0x0000) and the status register (offset 0x0004) read 0. No chip select or framer request is active, and `phy_rst` is high. The control register keeps only bits 4, 5, 8, 9, 10, 11 and 12, so a write of all ones reads back 0x1F30.
- R2: With control bit 9 = 0 (fixed mode), an external access holds its chip select and strobe for exactly ceil(FIXED_WINDOW_NS / CLK_PERIOD_NS) cycles (20 by default). A read returns the `phy_din` value present at the end of that window.
- R3: With control bit 9 = 1 (handshake mode), the strobe ends at the first clock edge where `phy_ack` is high. A read returns `phy_din` from that edge.
- R4: In handshake mode, if `phy_ack` is not seen within ACK_TIMEOUT strobe cycles (32 by default), the access ends after exactly ACK_TIMEOUT cycles. A read then returns 0, and status bit 4 is set.
- R5: A write drives `phy_dout` = host data[7:0] with `phy_dout_en` high. `phy_par_out` is set so that data plus parity hold an odd number of ones. A read whose data and `phy_par_in` hold an even count of ones sets status bit 1, but only when control bit 12 is 1. Writes never set status bit 1.
- R6: An interrupt input counts as active when it is low while control bit 11 is 0, and when it is high while control bit 11 is 1. An active `phy_irq[0]` sets status bit 2, and an active `phy_irq[1]` sets status bit 3.
- R7: `phy_rst` is low (reset asserted) when control bit 5 is 1 and bit 11 is 0. When bit 11 is 1, the polarity flips and `phy_rst` equals control bit 5.
- R8: With control bit 10 = 1, data-window offsets 0x2100 to 0x2FFF produce a single-cycle framer request carrying the low 12 address bits, with no PHY strobe. Offsets 0x2000 to 0x20FF in that mode end at once, read 0 and set status bit 5.
- R9: With control bit 10 = 0, window offsets 0x2000 to 0x2FFF go to the PHY bus. Address bit 11 picks PHY 2 (`phy_cs_n[1]` low) or PHY 1 (`phy_cs_n[0]` low), and address bits 7:0 drive `phy_addr`. At most one chip select is active at any time.
- R10: With control bit 4 = 0, a data-window access makes no bus or framer activity. It completes in the next cycle and reads 0.
- R11: While control bit 8 is 1 and `master_en` is low, control bit 4 is held at 0. A write cannot set it. With bit 8 clear, `master_en` has no effect.
- R12: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `host_done` pulses for exactly one cycle per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Host offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | An access is in progress |
| phy_cs_n | output | 2 | Active-low chip selects, [0] PHY 1, [1] PHY 2 |
| phy_rd_n | output | 1 | Active-low read strobe |
| phy_wr_n | output | 1 | Active-low write strobe |
| phy_addr | output | 8 | PHY register address |
| phy_dout | output | 8 | PHY write data |
| phy_dout_en | output | 1 | Write data drive enable |
| phy_par_out | output | 1 | Odd parity of phy_dout |
| phy_din | input | 8 | PHY read data |
| phy_par_in | input | 1 | Parity bit for phy_din |
| phy_ack | input | 1 | Transfer acknowledge (handshake mode) |
| phy_irq | input | 2 | PHY interrupt inputs |
| phy_rst | output | 1 | PHY reset output |
| master_en | input | 1 | External master enable |
| fr_req | output | 1 | Framer register access strobe |
| fr_we | output | 1 | Framer write |
| fr_addr | output | 12 | Framer register offset |
| fr_wdata | output | 8 | Framer write data |
| fr_rdata | input | 8 | Framer read data |

## Verification
The bench sweeps all 256 read data values with correct and broken parity and alternates the two PHYs. A parity generator of the wrong sense, or a check that ignores the enable bit, would then raise or miss the error bit. The acknowledge delay is swept across the timeout edge, including an acknowledge on the very last allowed cycle. An off-by-one counter would then show as a strobe one cycle too long or too short, or as a timeout when the acknowledge did arrive. All four interrupt levels are tried under both polarities, and both framer window edges are tried. A swapped polarity or a wrong window bound would set the wrong status bit or send the access to the wrong place.

// File: rtl/phy_bus_ctrl.sv
module phy_bus_ctrl #(
  parameter int CLK_PERIOD_NS   = 10,
  parameter int FIXED_WINDOW_NS = 200,
  parameter int ACK_TIMEOUT     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [13:0] host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_done,
  output logic        host_busy,
  output logic [1:0]  phy_cs_n,
  output logic        phy_rd_n,
  output logic        phy_wr_n,
  output logic [7:0]  phy_addr,
  output logic [7:0]  phy_dout,
  output logic        phy_dout_en,
  output logic        phy_par_out,
  input  logic [7:0]  phy_din,
  input  logic        phy_par_in,
  input  logic        phy_ack,
  input  logic [1:0]  phy_irq,
  output logic        phy_rst,
  input  logic        master_en,
  output logic        fr_req,
  output logic        fr_we,
  output logic [11:0] fr_addr,
  output logic [7:0]  fr_wdata,
  input  logic [7:0]  fr_rdata
);

  localparam int FIX_CYC = (FIXED_WINDOW_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CNT_MAX = (FIX_CYC > ACK_TIMEOUT) ? FIX_CYC : ACK_TIMEOUT;
  localparam int CW      = $clog2(CNT_MAX + 1);

  localparam int C_FE   = 4;
  localparam int C_PRST = 5;
  localparam int C_LINK = 8;
  localparam int C_HS   = 9;
  localparam int C_FRM  = 10;
  localparam int C_INV  = 11;
  localparam int C_PEN  = 12;
  localparam logic [15:0] CTRL_MASK = 16'h1F30;

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_FRM} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [15:0] ctrl, ctrl_n;
  logic [7:0]  stat, stat_set, stat_clr;
  logic        op_we, op_phy2;
  logic [11:0] op_addr;
  logic [7:0]  op_wdata;

  wire acc     = host_req && (st == S_IDLE);
  wire is_ctrl = (host_addr == 14'h0000);
  wire is_stat = (host_addr == 14'h0004);
  wire in_win  = (host_addr[13:12] == 2'b10);
  wire frm_hit = (host_addr[11:8] != 4'h0);
  wire fe      = ctrl[C_FE];
  wire hs      = ctrl[C_HS];
  wire go_bus  = acc && in_win && fe && !ctrl[C_FRM];
  wire go_frm  = acc && in_win && fe && ctrl[C_FRM] && frm_hit;
  wire adr_err = acc && in_win && fe && ctrl[C_FRM] && !frm_hit;

  wire fix_end = (st == S_STRB) && !hs && (cnt == CW'(FIX_CYC - 1));
  wire ack_end = (st == S_STRB) && hs && phy_ack;
  wire tmo_end = (st == S_STRB) && hs && !phy_ack && (cnt == CW'(ACK_TIMEOUT - 1));
  wire bus_fin = fix_end || ack_end || tmo_end;
  wire par_bad = ~^{phy_din, phy_par_in};
  wire par_ev  = (fix_end || ack_end) && !op_we && ctrl[C_PEN] && par_bad;

  wire [1:0] irq_act = ctrl[C_INV] ? phy_irq : ~phy_irq;

  always_comb begin
    ctrl_n = (acc && host_we && is_ctrl) ? (host_wdata & CTRL_MASK) : ctrl;
    if (ctrl_n[C_LINK] && !master_en) ctrl_n[C_FE] = 1'b0;
  end

  assign stat_set = {2'b00, adr_err, tmo_end, irq_act, par_ev, 1'b0};
  assign stat_clr = (acc && host_we && is_stat) ? host_wdata[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      ctrl       <= '0;
      stat       <= '0;
      op_we      <= 1'b0;
      op_phy2    <= 1'b0;
      op_addr    <= '0;
      op_wdata   <= '0;
      host_done  <= 1'b0;
      host_rdata <= '0;
    end else begin
      ctrl      <= ctrl_n;
      stat      <= (stat & ~stat_clr) | stat_set;
      host_done <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          op_we    <= host_we;
          op_phy2  <= host_addr[11];
          op_addr  <= host_addr[11:0];
          op_wdata <= host_wdata[7:0];
          cnt      <= '0;
          if (go_bus)      st <= S_STRB;
          else if (go_frm) st <= S_FRM;
          else begin
            host_done  <= 1'b1;
            host_rdata <= host_we ? 16'h0000 :
                          is_ctrl ? ctrl :
                          is_stat ? {8'h00, stat} : 16'h0000;
          end
        end
        S_STRB: begin
          cnt <= cnt + 1'b1;
          if (bus_fin) begin
            st         <= S_IDLE;
            host_done  <= 1'b1;
            host_rdata <= (op_we || tmo_end) ? 16'h0000 : {8'h00, phy_din};
          end
        end
        S_FRM: begin
          st         <= S_IDLE;
          host_done  <= 1'b1;
          host_rdata <= op_we ? 16'h0000 : {8'h00, fr_rdata};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign host_busy   = (st != S_IDLE);
  assign phy_cs_n    = (st != S_STRB) ? 2'b11 : (op_phy2 ? 2'b01 : 2'b10);
  assign phy_rd_n    = !((st == S_STRB) && !op_we);
  assign phy_wr_n    = !((st == S_STRB) && op_we);
  assign phy_addr    = op_addr[7:0];
  assign phy_dout    = op_wdata;
  assign phy_dout_en = (st == S_STRB) && op_we;
  assign phy_par_out = ~^op_wdata;
  assign phy_rst     = ~(ctrl[C_PRST] ^ ctrl[C_INV]);
  assign fr_req      = (st == S_FRM);
  assign fr_we       = op_we;
  assign fr_addr     = op_addr;
  assign fr_wdata    = op_wdata;

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~phy_cs_n));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rd_n || phy_wr_n);

  // R2
  fix_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRB && !hs) |-> (cnt < CW'(FIX_CYC)));

  // R4
  tmo_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRB && hs) |-> (cnt < CW'(ACK_TIMEOUT)));

  // R10
  fe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_win && !fe) |=> (host_done && phy_cs_n == 2'b11 && !fr_req));

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_act[0] |=> stat[2]);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

endmodule

// File: tb/phy_bus_ctrl_bench.sv
module phy_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FIXW = 20;
  localparam int TMO  = 32;
  localparam logic [15:0] FE = 16'h0010, PRST = 16'h0020, LINK = 16'h0100,
                          HS = 16'h0200, FRM = 16'h0400, INV = 16'h0800, PEN = 16'h1000;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [13:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic host_done, host_busy;
  logic [1:0] phy_cs_n;
  logic phy_rd_n, phy_wr_n, phy_dout_en, phy_par_out, phy_ack, phy_rst;
  logic [7:0] phy_addr, phy_dout, phy_din, fr_wdata, fr_rdata;
  logic phy_par_in;
  logic [1:0] phy_irq = 2'b11;
  logic master_en = 1;
  logic fr_req, fr_we;
  logic [11:0] fr_addr;

  logic [7:0] mdata = 0;
  logic mbad = 0, ack_on = 0;
  int ack_dly = 0, acnt = 0;
  int n_cmp = 0, n_bad = 0;

  assign phy_ack    = ack_on && (acnt > ack_dly);
  assign phy_din    = mdata;
  assign phy_par_in = (~^mdata) ^ mbad;
  assign fr_rdata   = fr_addr[7:0] ^ 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_bus_ctrl u_phy_bus_ctrl (.*);

  logic [7:0] c_addr, c_dout;
  logic c_par, c_rd, c_wr, c_frwe;
  logic [1:0] c_cs;
  logic [11:0] c_fraddr;
  logic [7:0] c_frwd;
  int scyc, fcyc;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [13:0] a, input logic [15:0] d,
                      output logic [15:0] rd);
    int guard = 0;
    acnt = 0; scyc = 0; fcyc = 0; c_cs = 0; c_rd = 0; c_wr = 0;
    @(negedge clk); host_req = 1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 0;
    while (!host_done) begin
      if (phy_cs_n != 2'b11) begin
        acnt++; scyc++; c_cs |= ~phy_cs_n;
        c_addr = phy_addr; c_dout = phy_dout; c_par = phy_par_out;
        c_rd |= !phy_rd_n; c_wr |= !phy_wr_n;
      end
      if (fr_req) begin
        fcyc++; c_frwe = fr_we; c_fraddr = fr_addr; c_frwd = fr_wdata;
      end
      guard++;
      if (guard > 200) begin
        chk(0, "xfer hang", guard, 0);
        break;
      end
      @(negedge clk);
    end
    rd = host_rdata;
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    logic [15:0] x;
    xfer(1, a, d, x);
  endtask

  task automatic rdr(input logic [13:0] a, output logic [15:0] v);
    xfer(0, a, 16'h0, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(phy_cs_n == 2'b11 && !fr_req, "R1 idle pins", phy_cs_n, 3);
    chk(phy_rst == 1, "R1 phy_rst", phy_rst, 1);
    rdr(14'h0000, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rdr(14'h0004, v); chk(v == 0, "R1 stat reset", v, 0);
    wr(14'h0000, 16'hFFFF); rdr(14'h0000, v); chk(v == 16'h1F30, "R1 ctrl mask", v, 16'h1F30);

    // R2 R5 R9 fixed-mode read sweep with parity
    wr(14'h0000, FE | PEN);
    wr(14'h0004, 16'h00FF);
    for (int i = 0; i < 512; i++) begin
      logic [13:0] a;
      logic [1:0] ecs;
      mdata = i[7:0]; mbad = i[8];
      a = 14'h2000 | (14'(i[0]) << 11) | 14'(i[7:0]);
      ecs = i[0] ? 2'b10 : 2'b01;
      rdr(a, v);
      chk(scyc == FIXW, "R2 fixed strobe length", scyc, FIXW);
      chk(v == {8'h0, i[7:0]}, "R2 read data", v, i[7:0]);
      chk(c_cs == ecs && c_addr == i[7:0] && c_rd && !c_wr, "R9 select/address", {c_cs, c_addr}, {ecs, i[7:0]});
      rdr(14'h0004, v);
      chk(v[1] == mbad, "R5 parity error bit", v[1], mbad);
      wr(14'h0004, 16'h0002);
    end
    rdr(14'h0004, v); chk(v[1] == 0, "R12 W1C clears bit 1", v[1], 0);
    mbad = 0;

    // R5 parity disabled, and writes
    wr(14'h0000, FE);
    mbad = 1; rdr(14'h2010, v);
    rdr(14'h0004, v); chk(v[1] == 0, "R5 parity check disabled", v[1], 0);
    wr(14'h0000, FE | PEN);
    for (int i = 0; i < 256; i += 17) begin
      wr(14'h2000 | 14'(i), 16'(i) | 16'hAB00);
      chk(c_dout == i[7:0] && c_wr && !c_rd, "R5 write data", c_dout, i[7:0]);
      chk((^{c_dout, c_par}) == 1'b1, "R5 odd parity out", c_par, ~^i[7:0]);
      chk(scyc == FIXW, "R2 write strobe length", scyc, FIXW);
    end
    rdr(14'h0004, v); chk(v[1] == 0, "R5 write never flags parity", v[1], 0);
    mbad = 0;

    // R3 R4 handshake sweep
    wr(14'h0000, FE | HS | PEN);
    ack_on = 1;
    for (int dly = 0; dly < TMO + 4; dly++) begin
      int exp_c;
      bit to;
      ack_dly = dly; mdata = 8'(dly * 7 + 3);
      to = (dly >= TMO);
      exp_c = to ? TMO : dly + 1;
      rdr(14'h2800 | 14'(dly), v);
      chk(scyc == exp_c, "R3 handshake strobe length", scyc, exp_c);
      chk(v == (to ? 16'h0 : {8'h0, mdata}), "R3 R4 handshake read data", v, to ? 0 : mdata);
      rdr(14'h0004, v);
      chk(v[4] == to, "R4 timeout bit", v[4], to);
      chk(v[1] == 0, "R5 no parity flag on good data", v[1], 0);
      wr(14'h0004, 16'h0010);
    end
    ack_on = 0;
    mbad = 1; rdr(14'h2001, v); mbad = 0;
    chk(scyc == TMO, "R4 no ack timeout length", scyc, TMO);
    rdr(14'h0004, v);
    chk(v[4] && !v[1], "R4 timeout without parity flag", v, 16'h10);
    ack_on = 1; ack_dly = 2; mbad = 1; rdr(14'h2001, v); mbad = 0;
    rdr(14'h0004, v);
    chk(v[4] && v[1], "R12 sticky bits", v, 16'h12);
    wr(14'h0004, 16'h0002); rdr(14'h0004, v);
    chk(v[4] && !v[1], "R12 W1C leaves others", v, 16'h10);
    wr(14'h0004, 16'h00FF);
    ack_on = 0;

    // R6 interrupts, R7 reset polarity
    for (int k = 0; k < 8; k++) begin
      logic inv;
      logic [1:0] lvl, act;
      inv = k[2]; lvl = k[1:0];
      act = inv ? lvl : ~lvl;
      phy_irq = lvl;
      wr(14'h0000, inv ? INV : 16'h0);
      wr(14'h0004, 16'h00FF);
      rdr(14'h0004, v);
      chk(v[3:2] == act, "R6 interrupt status", v[3:2], act);
    end
    phy_irq = 2'b11;
    for (int k = 0; k < 4; k++) begin
      logic ex;
      wr(14'h0000, (k[0] ? PRST : 16'h0) | (k[1] ? INV : 16'h0));
      ex = k[1] ? k[0] : ~k[0];
      @(negedge clk);
      chk(phy_rst == ex, "R7 reset output polarity", phy_rst, ex);
    end
    phy_irq = 2'b11;
    wr(14'h0000, 16'h0);
    wr(14'h0004, 16'h00FF);

    // R8 framer window
    wr(14'h0000, FE | FRM);
    for (int k = 0; k < 3; k++) begin
      logic [13:0] a;
      a = (k == 0) ? 14'h2100 : (k == 1) ? 14'h2FFF : 14'h2ABC;
      rdr(a, v);
      chk(fcyc == 1 && scyc == 0, "R8 framer single request", fcyc, 1);
      chk(c_fraddr == a[11:0] && !c_frwe, "R8 framer address", c_fraddr, a[11:0]);
      chk(v == {8'h0, a[7:0] ^ 8'h5A}, "R8 framer read data", v, a[7:0] ^ 8'h5A);
    end
    wr(14'h2345, 16'h0077);
    chk(c_frwe && c_fraddr == 12'h345 && c_frwd == 8'h77, "R8 framer write", c_frwd, 8'h77);
    rdr(14'h0004, v); chk(v[5] == 0, "R8 no address error in window", v[5], 0);
    rdr(14'h20FF, v);
    chk(fcyc == 0 && scyc == 0 && v == 0, "R8 below window", fcyc, 0);
    rdr(14'h0004, v); chk(v[5] == 1, "R8 address error bit", v[5], 1);
    wr(14'h0004, 16'h0020);
    wr(14'h0000, FE);
    rdr(14'h20FF, v);
    chk(scyc == FIXW && fcyc == 0, "R9 external covers whole window", scyc, FIXW);

    // R10 front end disabled
    wr(14'h0000, 16'h0);
    mdata = 8'h3C;
    rdr(14'h2000, v);
    chk(scyc == 0 && v == 0, "R10 no bus when disabled", scyc, 0);
    wr(14'h2800, 16'h55);
    chk(scyc == 0, "R10 no write when disabled", scyc, 0);
    wr(14'h0000, FRM);
    rdr(14'h2200, v);
    chk(fcyc == 0 && v == 0, "R10 no framer when disabled", fcyc, 0);

    // R11 hardware error link
    wr(14'h0000, FE | LINK);
    rdr(14'h0000, v); chk(v == (FE | LINK), "R11 enabled with master", v, FE | LINK);
    master_en = 0; @(negedge clk); @(negedge clk);
    rdr(14'h0000, v); chk(v == LINK, "R11 master low clears enable", v, LINK);
    wr(14'h0000, FE | LINK);
    rdr(14'h0000, v); chk(v == LINK, "R11 write cannot set enable", v, LINK);
    rdr(14'h2000, v); chk(scyc == 0, "R11 no bus after clear", scyc, 0);
    wr(14'h0000, FE);
    rdr(14'h0000, v); chk(v == FE, "R11 no link no effect", v, FE);
    master_en = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule